// File: doc/BRIEF.md
# Indirect Pointer Address Unit

This block turns one 16-bit load/store instruction word into a data-memory or program-memory access through a pointer held in the register file. Three 16-bit pointers are used: X in registers 27:26, Y in 29:28 and Z in 31:30. Each pair is stored low byte first. The surrounding pipeline reads the three pairs and the program-page register and presents them next to the instruction. The block then returns the effective address, a read or write strobe, the data register index, and the new pointer value to write back.

Three addressing forms are supported. The first uses the pointer unchanged. The second uses the pointer and then increments it. The third decrements the pointer and uses the new value. A separate displacement form adds a 6-bit constant to Y or Z and leaves the pointer unchanged. Program-memory byte reads use either the 16-bit Z pointer alone or a 24-bit pointer formed from the page register and Z. In the 24-bit case, a post-increment carries out of Z into the page register. Any program-memory byte at or beyond the configured memory size reads as 0xFF.

All results are registered. They appear in the clock cycle after the cycle in which `instr_valid` is sampled high. Each strobe is a single-cycle pulse.

Top module: `ptr_agu`

## Requirements
- R1: While reset is asserted and after it is released, `dm_rd`, `dm_wr`, `pm_rd`, `wb_en` and `pg_wb_en` are low until a valid instruction has been taken.
- R2: The word {6'b100100, s, ddddd, 4'b1100} is a plain X access: the address is X, there is no write-back, and s=1 gives `dm_wr` while s=0 gives `dm_rd`.
- R3: Post-increment uses {6'b100100, s, ddddd, pp, 2'b01}, where pp=11 selects X, 10 selects Y and 00 selects Z. The address is the old pointer. `wb_en` is set, `wb_idx` is 26, 28 or 30, and `wb_val` is the pointer plus 1.
- R4: Pre-decrement uses the same layout with the low two bits equal to 10. The address is the pointer minus 1, and the same value is written back.
- R5: The displacement form is {2'b10, q5, 1'b0, q4:q3, s, ddddd, y, q2:q0}. y=1 selects Y and y=0 selects Z. The address is the pointer plus q, and the pointer is not written back. With q=0 this form is the plain Y or Z access.
- R6: Data-pointer arithmetic wraps modulo 2^16. For example, X=FFFF with post-increment writes back 0000.
- R7: The load word {7'b1001000, ddddd, 3'b010, i} reads program memory at {0, Z}. When i=1, Z+1 (wrapping modulo 2^16) is written back to register 30 and the page register is not touched.
- R8: The load word {7'b1001000, ddddd, 3'b011, i} reads program memory at {page, Z}. When i=1, the 24-bit value plus 1 (wrapping modulo 2^24) is split: its low 16 bits go back to Z and its high 8 bits go to `pg_wb_val` with `pg_wb_en` set.
- R9: `pm_byte` equals `pm_rdata` when `pm_addr` < PM_BYTES, and 0xFF when `pm_addr` >= PM_BYTES.
- R10: Words with low nibble 1111 in the 1001_00x class (stack pop and push) produce no strobe and no write-back. The same holds for any word outside the forms above.
- R11: Results appear in the cycle after `instr_valid` is sampled. A cycle with `instr_valid` low produces no strobe, and at most one of `dm_rd`, `dm_wr`, `pm_rd` is high in any cycle.
- R12: `reg_idx` equals instruction bits 8:4 for every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| ptr_x | input | ADDR_W | Current X pointer |
| ptr_y | input | ADDR_W | Current Y pointer |
| ptr_z | input | ADDR_W | Current Z pointer |
| page_in | input | PAGE_W | Current program-page register |
| pm_rdata | input | 8 | Byte returned by program memory for `pm_addr` |
| dm_rd | output | 1 | Data-memory read strobe |
| dm_wr | output | 1 | Data-memory write strobe |
| dm_addr | output | ADDR_W | Data-memory effective address |
| reg_idx | output | 5 | Destination or source register index |
| wb_en | output | 1 | Pointer write-back enable |
| wb_idx | output | 5 | Low register index of the written pair |
| wb_val | output | ADDR_W | New pointer value |
| pm_rd | output | 1 | Program-memory byte read strobe |
| pm_addr | output | ADDR_W+PAGE_W | Program-memory byte address |
| pg_wb_en | output | 1 | Page register write-back enable |
| pg_wb_val | output | PAGE_W | New page register value |
| pm_byte | output | 8 | Program byte to load, 0xFF past the end |

## Verification
The bench builds the block with its default parameters: 16-bit pointers, an 8-bit page and PM_BYTES of 98304. With that size, program memory ends inside page 1. A handful of page/Z pairs can therefore reach the last valid byte (0x017FFF), the first missing one (0x018000), the carry from Z into the page, and the 24-bit wrap. Because pointers are 16 bits wide, the wrap of each data-pointer mode is reached directly at 0x0000 and 0xFFFF.

// File: rtl/ptr_agu.sv
module ptr_agu #(
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 8,
  parameter int PM_BYTES = 98304
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     instr_valid,
  input  logic [15:0]              instr,
  input  logic [ADDR_W-1:0]        ptr_x,
  input  logic [ADDR_W-1:0]        ptr_y,
  input  logic [ADDR_W-1:0]        ptr_z,
  input  logic [PAGE_W-1:0]        page_in,
  input  logic [7:0]               pm_rdata,
  output logic                     dm_rd,
  output logic                     dm_wr,
  output logic [ADDR_W-1:0]        dm_addr,
  output logic [4:0]               reg_idx,
  output logic                     wb_en,
  output logic [4:0]               wb_idx,
  output logic [ADDR_W-1:0]        wb_val,
  output logic                     pm_rd,
  output logic [ADDR_W+PAGE_W-1:0] pm_addr,
  output logic                     pg_wb_en,
  output logic [PAGE_W-1:0]        pg_wb_val,
  output logic [7:0]               pm_byte
);
  localparam int PMW = ADDR_W + PAGE_W;
  localparam logic [4:0] IDX_X = 5'd26;
  localparam logic [4:0] IDX_Y = 5'd28;
  localparam logic [4:0] IDX_Z = 5'd30;

  wire       is_ind  = instr[15:10] == 6'b100100;
  wire       is_disp = instr[15:14] == 2'b10 && !instr[12];
  wire [3:0] nib     = instr[3:0];
  wire [5:0] q       = {instr[13], instr[11:10], instr[2:0]};

  logic              c_dm, c_st, c_wb, c_pm, c_pg;
  logic [ADDR_W-1:0] c_addr, c_wbval, base;
  logic [4:0]        c_wbidx, bidx;
  logic [PMW-1:0]    c_pmaddr, ext, ext1;
  logic [PAGE_W-1:0] c_pgval;

  always_comb begin
    c_dm = 1'b0; c_st = 1'b0; c_wb = 1'b0; c_pm = 1'b0; c_pg = 1'b0;
    c_addr = '0; c_wbval = '0; c_wbidx = '0; c_pmaddr = '0; c_pgval = '0;
    base = ptr_z; bidx = IDX_Z;
    ext  = {page_in, ptr_z};
    ext1 = ext + PMW'(1);
    if (is_disp) begin
      base   = instr[3] ? ptr_y : ptr_z;
      c_dm   = 1'b1;
      c_st   = instr[9];
      c_addr = base + ADDR_W'(q);
    end else if (is_ind) begin
      case (nib[3:2])
        2'b11: begin base = ptr_x; bidx = IDX_X; end
        2'b10: begin base = ptr_y; bidx = IDX_Y; end
        default: begin base = ptr_z; bidx = IDX_Z; end
      endcase
      if (nib[3:2] == 2'b01) begin
        if (!instr[9]) begin
          c_pm = 1'b1;
          if (nib[1]) begin
            c_pmaddr = ext;
            if (nib[0]) begin
              c_wb = 1'b1; c_wbidx = IDX_Z; c_wbval = ext1[ADDR_W-1:0];
              c_pg = 1'b1; c_pgval = ext1[PMW-1:ADDR_W];
            end
          end else begin
            c_pmaddr = {{PAGE_W{1'b0}}, ptr_z};
            if (nib[0]) begin
              c_wb = 1'b1; c_wbidx = IDX_Z; c_wbval = ptr_z + ADDR_W'(1);
            end
          end
        end
      end else begin
        case (nib[1:0])
          2'b00: if (nib[3:2] == 2'b11) begin
            c_dm = 1'b1; c_st = instr[9]; c_addr = base;
          end
          2'b01: begin
            c_dm = 1'b1; c_st = instr[9]; c_addr = base;
            c_wb = 1'b1; c_wbidx = bidx; c_wbval = base + ADDR_W'(1);
          end
          2'b10: begin
            c_dm = 1'b1; c_st = instr[9]; c_addr = base - ADDR_W'(1);
            c_wb = 1'b1; c_wbidx = bidx; c_wbval = base - ADDR_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dm_rd <= 1'b0; dm_wr <= 1'b0; pm_rd <= 1'b0;
      wb_en <= 1'b0; pg_wb_en <= 1'b0;
      dm_addr <= '0; reg_idx <= '0; wb_idx <= '0; wb_val <= '0;
      pm_addr <= '0; pg_wb_val <= '0;
    end else begin
      dm_rd    <= instr_valid && c_dm && !c_st;
      dm_wr    <= instr_valid && c_dm && c_st;
      pm_rd    <= instr_valid && c_pm;
      wb_en    <= instr_valid && c_wb;
      pg_wb_en <= instr_valid && c_pg;
      if (instr_valid) begin
        dm_addr   <= c_addr;
        reg_idx   <= instr[8:4];
        wb_idx    <= c_wbidx;
        wb_val    <= c_wbval;
        pm_addr   <= c_pmaddr;
        pg_wb_val <= c_pgval;
      end
    end
  end

  assign pm_byte = (32'(pm_addr) >= PM_BYTES) ? 8'hFF : pm_rdata;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !(dm_rd || dm_wr || pm_rd || wb_en || pg_wb_en)); // R1
  AST_WB_PAIR: assert property (@(posedge clk) disable iff (!rst_n) wb_en |-> (wb_idx == IDX_X || wb_idx == IDX_Y || wb_idx == IDX_Z)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n) wb_en && (dm_rd || dm_wr) |-> (wb_val == dm_addr || wb_val == ADDR_W'(dm_addr + ADDR_W'(1)))); // R4
  AST_PAGE_WITH_PM: assert property (@(posedge clk) disable iff (!rst_n) pg_wb_en |-> pm_rd && wb_en && wb_idx == IDX_Z); // R8
  AST_STACK_SKIP: assert property (@(posedge clk) disable iff (!rst_n) instr_valid && instr[15:10] == 6'b100100 && instr[3:0] == 4'hF |=> !(dm_rd || dm_wr || wb_en)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !instr_valid |=> !(dm_rd || dm_wr || pm_rd || wb_en)); // R11
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({dm_rd, dm_wr, pm_rd})); // R11
endmodule

// File: tb/test_ptr_agu.sv
module test_ptr_agu;
  localparam int PERIOD = 10;
  localparam logic [7:0] PMD = 8'h5A;

  typedef struct {
    logic rd, wr, pm, wb, pg;
    logic [15:0] addr, wbv;
    logic [4:0] ridx, widx;
    logic [23:0] pma;
    logic [7:0] pgv, byt;
    string tag;
  } exp_t;

  logic clk = 0, rst_n = 0, instr_valid = 0;
  logic [15:0] instr = 0, ptr_x = 0, ptr_y = 0, ptr_z = 0;
  logic [7:0] page_in = 0, pm_rdata = PMD;
  logic dm_rd, dm_wr, wb_en, pm_rd, pg_wb_en;
  logic [15:0] dm_addr, wb_val;
  logic [4:0] reg_idx, wb_idx;
  logic [23:0] pm_addr;
  logic [7:0] pg_wb_val, pm_byte;
  int checks = 0, errors = 0;
  exp_t q[$];

  ptr_agu i_ptr_agu (.clk, .rst_n, .instr_valid, .instr, .ptr_x, .ptr_y, .ptr_z,
    .page_in, .pm_rdata, .dm_rd, .dm_wr, .dm_addr, .reg_idx, .wb_en, .wb_idx,
    .wb_val, .pm_rd, .pm_addr, .pg_wb_en, .pg_wb_val, .pm_byte);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string what, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t e_none(string tag);
    exp_t e;
    e.rd = 0; e.wr = 0; e.pm = 0; e.wb = 0; e.pg = 0;
    e.addr = 0; e.wbv = 0; e.ridx = 0; e.widx = 0; e.pma = 0; e.pgv = 0; e.byt = 0;
    e.tag = tag;
    return e;
  endfunction

  function automatic exp_t e_dm(logic st, logic [15:0] a, logic [4:0] r, logic wb,
                                logic [4:0] wi, logic [15:0] wv, string tag);
    exp_t e = e_none(tag);
    e.rd = !st; e.wr = st; e.addr = a; e.ridx = r; e.wb = wb; e.widx = wi; e.wbv = wv;
    return e;
  endfunction

  function automatic exp_t e_pm(logic [23:0] a, logic [4:0] r, logic wb, logic [15:0] wv,
                                logic pg, logic [7:0] pv, logic [7:0] b, string tag);
    exp_t e = e_none(tag);
    e.pm = 1; e.pma = a; e.ridx = r; e.wb = wb; e.widx = 5'd30; e.wbv = wv;
    e.pg = pg; e.pgv = pv; e.byt = b;
    return e;
  endfunction

  function automatic logic [15:0] w_ind(logic st, logic [4:0] d, logic [3:0] n);
    return {6'b100100, st, d, n};
  endfunction

  function automatic logic [15:0] w_disp(logic st, logic [4:0] d, logic ysel, logic [5:0] qq);
    return {2'b10, qq[5], 1'b0, qq[4:3], st, d, ysel, qq[2:0]};
  endfunction

  task automatic issue(logic [15:0] w, logic [15:0] x, logic [15:0] y, logic [15:0] z,
                       logic [7:0] pg, exp_t e);
    @(negedge clk);
    instr_valid = 1; instr = w; ptr_x = x; ptr_y = y; ptr_z = z; page_in = pg;
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    instr_valid = 0; instr = w_ind(0, 5'd1, 4'b1101);
    q.push_back(e_none(tag));
  endtask

  initial begin : monitor
    exp_t e;
    @(posedge rst_n);
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk("strobes", e.tag, {29'd0, dm_rd, dm_wr, pm_rd}, {29'd0, e.rd, e.wr, e.pm});
        chk("wb_en", e.tag, {31'd0, wb_en}, {31'd0, e.wb});
        chk("pg_wb_en", e.tag, {31'd0, pg_wb_en}, {31'd0, e.pg});
        if (e.rd || e.wr) chk("dm_addr", e.tag, {16'd0, dm_addr}, {16'd0, e.addr});
        if (e.rd || e.wr || e.pm) chk("reg_idx R12", e.tag, {27'd0, reg_idx}, {27'd0, e.ridx});
        if (e.wb) begin
          chk("wb_idx", e.tag, {27'd0, wb_idx}, {27'd0, e.widx});
          chk("wb_val", e.tag, {16'd0, wb_val}, {16'd0, e.wbv});
        end
        if (e.pg) chk("pg_wb_val", e.tag, {24'd0, pg_wb_val}, {24'd0, e.pgv});
        if (e.pm) begin
          chk("pm_addr", e.tag, {8'd0, pm_addr}, {8'd0, e.pma});
          chk("pm_byte", e.tag, {24'd0, pm_byte}, {24'd0, e.byt});
        end
      end
    end
  end

  initial begin : watchdog
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    chk("strobes in reset", "R1", {27'd0, dm_rd, dm_wr, pm_rd, wb_en, pg_wb_en}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("strobes after reset", "R1", {27'd0, dm_rd, dm_wr, pm_rd, wb_en, pg_wb_en}, 32'd0);

    issue(w_ind(0, 5'd5, 4'b1100), 16'h1234, 0, 0, 0, e_dm(0, 16'h1234, 5'd5, 0, 0, 0, "R2 ld X"));
    issue(w_ind(1, 5'd17, 4'b1100), 16'h1234, 0, 0, 0, e_dm(1, 16'h1234, 5'd17, 0, 0, 0, "R2 st X"));
    issue(w_ind(0, 5'd3, 4'b1101), 16'h0100, 0, 0, 0, e_dm(0, 16'h0100, 5'd3, 1, 5'd26, 16'h0101, "R3 ld X+"));
    issue(w_ind(1, 5'd9, 4'b1001), 0, 16'h2000, 0, 0, e_dm(1, 16'h2000, 5'd9, 1, 5'd28, 16'h2001, "R3 st Y+"));
    issue(w_ind(0, 5'd11, 4'b0001), 0, 0, 16'h4444, 0, e_dm(0, 16'h4444, 5'd11, 1, 5'd30, 16'h4445, "R3 ld Z+"));
    issue(w_ind(0, 5'd20, 4'b0010), 0, 0, 16'h3000, 0, e_dm(0, 16'h2FFF, 5'd20, 1, 5'd30, 16'h2FFF, "R4 ld -Z"));
    issue(w_ind(1, 5'd1, 4'b1110), 16'h0010, 0, 0, 0, e_dm(1, 16'h000F, 5'd1, 1, 5'd26, 16'h000F, "R4 st -X"));
    issue(w_ind(0, 5'd7, 4'b1010), 0, 16'h0800, 0, 0, e_dm(0, 16'h07FF, 5'd7, 1, 5'd28, 16'h07FF, "R4 ld -Y"));
    issue(w_disp(0, 5'd4, 1, 6'b101010), 0, 16'h1000, 16'h9999, 0, e_dm(0, 16'h102A, 5'd4, 0, 0, 0, "R5 ldd Y+42"));
    issue(w_disp(1, 5'd6, 0, 6'b010101), 0, 16'h7777, 16'h0400, 0, e_dm(1, 16'h0415, 5'd6, 0, 0, 0, "R5 std Z+21"));
    issue(w_disp(0, 5'd2, 1, 6'd0), 0, 16'hBEEF, 0, 0, e_dm(0, 16'hBEEF, 5'd2, 0, 0, 0, "R5 ld Y q0"));
    issue(w_ind(0, 5'd8, 4'b1101), 16'hFFFF, 0, 0, 0, e_dm(0, 16'hFFFF, 5'd8, 1, 5'd26, 16'h0000, "R6 X+ wrap"));
    issue(w_ind(1, 5'd8, 4'b1010), 0, 16'h0000, 0, 0, e_dm(1, 16'hFFFF, 5'd8, 1, 5'd28, 16'hFFFF, "R6 -Y wrap"));
    issue(w_disp(0, 5'd8, 0, 6'd63), 0, 0, 16'hFFF0, 0, e_dm(0, 16'h002F, 5'd8, 0, 0, 0, "R6 Z+63 wrap"));
    issue(w_ind(0, 5'd12, 4'b1111), 16'h1111, 0, 0, 0, e_none("R10 pop"));
    issue(w_ind(1, 5'd12, 4'b1111), 16'h1111, 0, 0, 0, e_none("R10 push"));
    issue(16'h0000, 16'h1111, 0, 0, 0, e_none("R10 other word"));
    issue(w_ind(0, 5'd0, 4'b0100), 0, 0, 16'h1234, 8'h01, e_pm(24'h001234, 5'd0, 0, 0, 0, 0, PMD, "R7 short pm"));
    issue(w_ind(0, 5'd0, 4'b0101), 0, 0, 16'hFFFF, 8'h01, e_pm(24'h00FFFF, 5'd0, 1, 16'h0000, 0, 0, PMD, "R7 short pm inc"));
    issue(w_ind(0, 5'd14, 4'b0110), 0, 0, 16'h7FFF, 8'h01, e_pm(24'h017FFF, 5'd14, 0, 0, 0, 0, PMD, "R9 last byte"));
    issue(w_ind(0, 5'd14, 4'b0110), 0, 0, 16'h8000, 8'h01, e_pm(24'h018000, 5'd14, 0, 0, 0, 0, 8'hFF, "R9 past end"));
    issue(w_ind(0, 5'd15, 4'b0111), 0, 0, 16'hFFFF, 8'h01, e_pm(24'h01FFFF, 5'd15, 1, 16'h0000, 1, 8'h02, 8'hFF, "R8 page carry"));
    issue(w_ind(0, 5'd15, 4'b0111), 0, 0, 16'h0010, 8'h00, e_pm(24'h000010, 5'd15, 1, 16'h0011, 1, 8'h00, PMD, "R8 ext inc"));
    issue(w_ind(0, 5'd15, 4'b0111), 0, 0, 16'hFFFF, 8'hFF, e_pm(24'hFFFFFF, 5'd15, 1, 16'h0000, 1, 8'h00, 8'hFF, "R8 ext wrap"));
    idle("R11 idle");
    issue(w_ind(0, 5'd31, 4'b0001), 0, 0, 16'h0042, 0, e_dm(0, 16'h0042, 5'd31, 1, 5'd30, 16'h0043, "R11 after idle"));
    idle("R11 idle2");

    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule